// File: doc/BRIEF.md
# Framed Word Serializer with Overclock Cadence

This block takes 12-bit parallel words, each marked by a rising edge on a strobe input, and sends them out one bit per bit-clock enable as framed serial words. A forwarded clock pulse travels with every bit, so a receiver can recover the stream without a clock of its own. The bit rate comes from the reference clock, which may run at the strobe rate or faster. Any word slot that has no pending word carries an all-zero frame, so the line never holds stale data.

Two slot cadences exist. In the standard cadence every word slot is 14 bits long. In the overclocked cadence the slots repeat as 14, 14 and then 16 bits, and the two extra bits of a long slot are zero. Each frame starts with a 1 bit, carries the data least significant bit first, and ends with a 0 bit. A word that arrives while a frame is on the line waits in a one-word holding register. A strobe that finds that register still full sets a sticky overflow flag. Power-down clears all state and turns the serial outputs off.

Top module: `frame_serializer`

## Requirements
- R1: A word is captured only on a 0-to-1 transition of `strobe_i`. A strobe that stays high for many cycles yields exactly one frame.
- R2: A frame is, in line order, a start bit of 1, then `data_i[0]` through `data_i[11]`, then a stop bit of 0.
- R3: With `ovck_i` = 0, every word slot lasts 14 bit periods. Slots run back to back from the first bit after reset or power-down.
- R4: With `ovck_i` = 1, slot lengths repeat 14, 14, 16, starting with the first slot after reset. Bits 14 and 15 of a 16-bit slot are 0.
- R5: A slot that begins with no word pending carries all zeros, start bit included.
- R6: A strobe that arrives while a frame is being shifted keeps its word in the holding register. That word goes out in the next slot, and words leave in the order they were strobed.
- R7: A strobe that arrives while the holding register is full, and is not being emptied in that cycle, sets `ovf_o`. Its word is dropped. `ovf_o` stays set until reset or power-down.
- R8: `fwd_clk_o` is high for exactly the cycle after each cycle in which `bit_en_i` is high, and low otherwise. `ser_o` changes only in cycles where `fwd_clk_o` is high, so data and clock are edge-aligned.
- R9: One cycle after `pwrdn_i` is sampled high, `oe_o`, `ser_o`, `fwd_clk_o` and `ovf_o` are 0. A held word is discarded and the slot cadence restarts.
- R10: While `rst_n` is low, `oe_o`, `ser_o`, `fwd_clk_o` and `ovf_o` are 0. `oe_o` goes to 1 in the first cycle after reset is released while `pwrdn_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic is on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pwrdn_i | input | 1 | Power-down; clears state and disables the outputs |
| bit_en_i | input | 1 | Bit-clock enable; one serial bit per high cycle |
| ovck_i | input | 1 | Cadence select: 0 gives 14-bit slots, 1 gives the 14/14/16 pattern |
| strobe_i | input | 1 | Word strobe; a rising edge captures `data_i` |
| data_i | input | 12 | Parallel word to send |
| ser_o | output | 1 | Serial data |
| fwd_clk_o | output | 1 | Forwarded bit clock, one pulse per bit |
| oe_o | output | 1 | Output enable for the serial driver pair |
| ovf_o | output | 1 | Sticky flag: a strobe found the holding register full |

## Verification
The bench records every bit marked by a forwarded-clock pulse and decodes the stream at the slot boundaries it works out for itself. If the overclocked cadence lost its 16-bit slot, or padded the wrong slot, later words would decode shifted and wrong. A strobe level held high for many cycles checks that a design capturing on level rather than on edge sends a string of duplicate frames. The hold-and-overflow scenario sends one word, then a second while the first is in flight, then a third. A design that overwrote the held word, or flagged too early, shows the wrong words or an early flag. Power-down with a held word pending checks that the word is not sent later. Throttled bit enables check that data never moves without a clock pulse.

// File: rtl/fser_pkg.sv
// Shared constants and types for the framed word serializer.
// Assumes: frames are start(1) + data + stop(0); a long slot adds zero padding.
package fser_pkg;
    parameter int FSER_DATA_W  = 12;  // payload bits per word
    parameter int FSER_PAD_W   = 2;   // extra zero bits in a long slot
    parameter int FSER_CAD_N   = 3;   // slots per overclock cadence period

    typedef enum logic {
        CAD_STD  = 1'b0,
        CAD_OVCK = 1'b1
    } cadence_e;
endpackage

// File: rtl/fser_capture.sv
// Strobe edge capture and one-word holding register.
// Captures data_i on a rising strobe. Flags overflow when a strobe finds the
// register full and not being drained in that same cycle; the new word is dropped.
// Assumes strobe_i is synchronous to clk.
module fser_capture #(
    parameter int DATA_W = fser_pkg::FSER_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              consume_i,
    output logic              hold_v_o,
    output logic [DATA_W-1:0] hold_d_o,
    output logic              ovf_o
);
    logic              strobe_q;
    logic              hold_v_q;
    logic [DATA_W-1:0] hold_d_q;
    logic              ovf_q;
    logic              rise;

    // Detect a 0-to-1 transition of the strobe.
    assign rise = strobe_i & ~strobe_q;

    // Holding register, strobe history and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            strobe_q <= strobe_i;
            hold_v_q <= 1'b0;
            hold_d_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
            if (rise) begin
                if (hold_v_q && !consume_i) begin
                    ovf_q <= 1'b1;
                end else begin
                    hold_d_q <= data_i;
                    hold_v_q <= 1'b1;
                end
            end else if (consume_i) begin
                hold_v_q <= 1'b0;
            end
        end
    end

    assign hold_v_o = hold_v_q;
    assign hold_d_o = hold_d_q;
    assign ovf_o    = ovf_q;
endmodule

// File: rtl/fser_slot_timer.sv
// Bit position within the current word slot, and the cadence phase.
// Standard cadence: every slot is FRAME_W bits. Overclock cadence: the last
// phase of each CAD_N-slot period is FRAME_W+PAD_W bits long.
// Assumes ovck_i is static while data flows.
module fser_slot_timer #(
    parameter int DATA_W = fser_pkg::FSER_DATA_W,
    parameter int PAD_W  = fser_pkg::FSER_PAD_W,
    parameter int CAD_N  = fser_pkg::FSER_CAD_N,
    localparam int FRAME_W = DATA_W + 2,
    localparam int LONG_W  = FRAME_W + PAD_W,
    localparam int IDX_W   = $clog2(LONG_W),
    localparam int PH_W    = (CAD_N > 1) ? $clog2(CAD_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             bit_en_i,
    input  logic             ovck_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             slot_start_o
);
    localparam logic [IDX_W-1:0] LAST_STD  = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] LAST_LONG = IDX_W'(LONG_W - 1);
    localparam logic [PH_W-1:0]  LAST_PH   = PH_W'(CAD_N - 1);

    logic [IDX_W-1:0] idx_q;
    logic [PH_W-1:0]  phase_q;
    logic [IDX_W-1:0] last_idx;
    fser_pkg::cadence_e cad;

    assign cad = fser_pkg::cadence_e'(ovck_i);

    // Pick this slot's final bit position from the cadence and phase.
    always_comb begin
        if (cad == fser_pkg::CAD_OVCK && phase_q == LAST_PH) last_idx = LAST_LONG;
        else                                                  last_idx = LAST_STD;
    end

    // Advance the bit position and, at slot end, the cadence phase.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            idx_q   <= '0;
            phase_q <= '0;
        end else if (bit_en_i) begin
            if (idx_q == last_idx) begin
                idx_q <= '0;
                if (cad == fser_pkg::CAD_OVCK) phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
                else                           phase_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idx_o        = idx_q;
    assign slot_start_o = (idx_q == '0);
endmodule

// File: rtl/fser_framer.sv
// Builds the serial bit stream and the forwarded clock.
// At a slot start it loads the held word (or zeros) into a shift register and
// emits the start bit; data goes out LSB first, then stop and padding zeros.
// Assumes idx_i and slot_start_i come from the slot timer for the same bit.
module fser_framer #(
    parameter int DATA_W = fser_pkg::FSER_DATA_W,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              bit_en_i,
    input  logic              slot_start_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              hold_v_i,
    input  logic [DATA_W-1:0] hold_d_i,
    output logic              ser_o,
    output logic              fwd_clk_o,
    output logic              oe_o
);
    logic [DATA_W-1:0] sh_q;
    logic              ser_q;
    logic              fwd_q;
    logic              oe_q;
    logic              in_data;

    // Data bits occupy slot positions 1 through DATA_W.
    assign in_data = (idx_i != '0) && (idx_i <= IDX_W'(DATA_W));

    // Output registers: serial bit, clock pulse and enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q  <= '0;
            ser_q <= 1'b0;
            fwd_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            oe_q  <= 1'b1;
            fwd_q <= bit_en_i;
            if (bit_en_i) begin
                if (slot_start_i) begin
                    ser_q <= hold_v_i;
                    sh_q  <= hold_v_i ? hold_d_i : '0;
                end else if (in_data) begin
                    ser_q <= sh_q[0];
                    sh_q  <= sh_q >> 1;
                end else begin
                    ser_q <= 1'b0;
                end
            end
        end
    end

    assign ser_o     = ser_q;
    assign fwd_clk_o = fwd_q;
    assign oe_o      = oe_q;
endmodule

// File: rtl/frame_serializer.sv
// Top level of the framed word serializer: strobe capture, slot timing and
// framing. Power-down acts as a synchronous clear of every register.
// Assumes all inputs are synchronous to clk.
module frame_serializer #(
    parameter int DATA_W = fser_pkg::FSER_DATA_W,
    parameter int PAD_W  = fser_pkg::FSER_PAD_W,
    parameter int CAD_N  = fser_pkg::FSER_CAD_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_i,
    input  logic              bit_en_i,
    input  logic              ovck_i,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ser_o,
    output logic              fwd_clk_o,
    output logic              oe_o,
    output logic              ovf_o
);
    localparam int IDX_W = $clog2(DATA_W + 2 + PAD_W);

    logic              hold_v;
    logic [DATA_W-1:0] hold_d;
    logic [IDX_W-1:0]  idx;
    logic              slot_start;
    logic              consume;

    // The held word moves to the line when a slot starts on an enabled bit.
    assign consume = bit_en_i & slot_start;

    fser_capture #(.DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (pwrdn_i),
        .strobe_i  (strobe_i),
        .data_i    (data_i),
        .consume_i (consume),
        .hold_v_o  (hold_v),
        .hold_d_o  (hold_d),
        .ovf_o     (ovf_o)
    );

    fser_slot_timer #(.DATA_W(DATA_W), .PAD_W(PAD_W), .CAD_N(CAD_N)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (pwrdn_i),
        .bit_en_i     (bit_en_i),
        .ovck_i       (ovck_i),
        .idx_o        (idx),
        .slot_start_o (slot_start)
    );

    fser_framer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr_i        (pwrdn_i),
        .bit_en_i     (bit_en_i),
        .slot_start_i (slot_start),
        .idx_i        (idx),
        .hold_v_i     (hold_v),
        .hold_d_i     (hold_d),
        .ser_o        (ser_o),
        .fwd_clk_o    (fwd_clk_o),
        .oe_o         (oe_o)
    );
endmodule

// File: rtl/fser_checker.sv
// Port-level protocol checks for frame_serializer, attached by bind.
// Assumes it sees the top-level ports only.
module fser_checker (
    input logic clk,
    input logic rst_n,
    input logic pwrdn_i,
    input logic bit_en_i,
    input logic strobe_i,
    input logic ser_o,
    input logic fwd_clk_o,
    input logic oe_o,
    input logic ovf_o
);
    // R9: power-down silences the outputs and clears the flag one cycle later.
    a_r9_pwrdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn_i |=> (!oe_o && !ser_o && !fwd_clk_o && !ovf_o));

    // R8: every enabled bit produces a clock pulse in the next cycle.
    a_r8_fwd_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en_i && !pwrdn_i) |=> fwd_clk_o);

    // R8: no clock pulse without an enabled bit.
    a_r8_fwd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en_i |=> !fwd_clk_o);

    // R8: data moves only together with a clock pulse.
    a_r8_edge_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && !$stable(ser_o)) |-> fwd_clk_o);

    // R7: the overflow flag holds until power-down.
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !pwrdn_i) |=> ovf_o);

    // R7: the overflow flag only rises after a strobe was high.
    a_r7_ovf_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(strobe_i));
endmodule

bind frame_serializer fser_checker u_fser_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwrdn_i   (pwrdn_i),
    .bit_en_i  (bit_en_i),
    .strobe_i  (strobe_i),
    .ser_o     (ser_o),
    .fwd_clk_o (fwd_clk_o),
    .oe_o      (oe_o),
    .ovf_o     (ovf_o)
);

// File: tb/frame_serializer_tb.sv
// Directed bench for frame_serializer: records bits marked by the forwarded
// clock and decodes them at independently computed slot boundaries.
module frame_serializer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn_i = 1'b0;
    logic        bit_en_i = 1'b1;
    logic        ovck_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic [11:0] data_i = '0;
    logic        ser_o, fwd_clk_o, oe_o, ovf_o;

    int checks = 0;
    int errors = 0;

    logic bits [0:4095];
    int   nbits = 0;
    int   exp_w [0:15];
    int   exp_n = 0;

    always #2.5 clk = ~clk;

    frame_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .pwrdn_i(pwrdn_i), .bit_en_i(bit_en_i),
        .ovck_i(ovck_i), .strobe_i(strobe_i), .data_i(data_i),
        .ser_o(ser_o), .fwd_clk_o(fwd_clk_o), .oe_o(oe_o), .ovf_o(ovf_o)
    );

    // Record each bit qualified by a clock pulse; restart when outputs are off.
    always @(negedge clk) begin
        if (!oe_o) nbits = 0;
        else if (fwd_clk_o && nbits < 4096) begin
            bits[nbits] = ser_o;
            nbits++;
        end
    end

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R10 reset state, then release with the chosen cadence.
    task automatic do_reset(input logic ovck);
        @(negedge clk);
        rst_n = 1'b0; pwrdn_i = 1'b0; bit_en_i = 1'b1; strobe_i = 1'b0; ovck_i = ovck;
        run(3);
        check("R10", {oe_o, ser_o, fwd_clk_o, ovf_o}, 0, "outputs in reset");
        rst_n = 1'b1;
        exp_n = 0;
    endtask

    task automatic pulse_strobe(input int d);
        @(negedge clk);
        strobe_i = 1'b1; data_i = 12'(d);
        @(negedge clk);
        strobe_i = 1'b0;
        exp_w[exp_n] = d; exp_n++;
    endtask

    task automatic wait_start_bit();
        do @(negedge clk); while (!(fwd_clk_o && ser_o));
    endtask

    // Decode whole slots (R2..R5) and compare with the words expected in order.
    task automatic decode(input logic ovck, input string tag);
        int p = 0; int k = 0; int bad = 0; int rx_n = 0;
        int rx [0:31];
        while (1) begin
            int len = (ovck && (k % 3 == 2)) ? 16 : 14;
            if (p + len > nbits) break;
            if (bits[p]) begin
                int w = 0;
                for (int j = 0; j < 12; j++) if (bits[p+1+j]) w |= (1 << j);
                for (int j = 13; j < len; j++) if (bits[p+j]) bad++;
                if (rx_n < 32) rx[rx_n] = w;
                rx_n++;
            end else begin
                for (int j = 0; j < len; j++) if (bits[p+j]) bad++;
            end
            p += len; k++;
        end
        check(tag, bad, 0, "nonzero stop/pad/idle bits");
        check(tag, rx_n, exp_n, "frames received");
        for (int i = 0; i < exp_n && i < rx_n; i++)
            check(tag, rx[i], exp_w[i], "frame payload");
    endtask

    task automatic t_idle();
        do_reset(1'b0);
        @(negedge clk);
        check("R10", oe_o, 1, "oe after release");
        run(70);
        check("R5", (nbits >= 56) ? 1 : 0, 1, "idle slots observed");
        decode(1'b0, "R5");
        check("R7", ovf_o, 0, "no overflow when idle");
    endtask

    task automatic t_standard();
        do_reset(1'b0);
        pulse_strobe(12'hA5C); run(30);
        pulse_strobe(12'h001); run(30);
        pulse_strobe(12'hFFF); run(40);
        decode(1'b0, "R2_R3");
    endtask

    task automatic t_overclock();
        do_reset(1'b1);
        for (int i = 0; i < 5; i++) begin
            pulse_strobe(12'h3C1 + i * 12'h111); run(20);
        end
        run(50);
        decode(1'b1, "R4");
        check("R4", ovf_o, 0, "no overflow at strobe spacing above slot length");
    endtask

    task automatic t_long_strobe();
        do_reset(1'b0);
        @(negedge clk);
        strobe_i = 1'b1; data_i = 12'h5A3;
        exp_w[0] = 12'h5A3; exp_n = 1;
        run(50);
        strobe_i = 1'b0;
        run(40);
        decode(1'b0, "R1");
    endtask

    task automatic t_hold_overflow();
        do_reset(1'b0);
        pulse_strobe(12'h111);
        wait_start_bit();
        pulse_strobe(12'h222);
        check("R6", ovf_o, 0, "held word while frame in flight");
        @(negedge clk);
        strobe_i = 1'b1; data_i = 12'h333;
        @(negedge clk);
        strobe_i = 1'b0;
        check("R7", ovf_o, 1, "overflow on third strobe");
        run(50);
        check("R7", ovf_o, 1, "overflow flag sticky");
        decode(1'b0, "R6_R7");
    endtask

    task automatic t_gapped();
        int mism = 0;
        logic prev_en = 1'b1;
        do_reset(1'b0);
        exp_w[0] = 12'h6B2; exp_n = 1;
        for (int i = 0; i < 180; i++) begin
            @(negedge clk);
            if (fwd_clk_o !== prev_en) mism++;
            bit_en_i = (i % 3 == 0);
            prev_en  = bit_en_i;
            strobe_i = (i == 4) || (i == 5);
            data_i   = 12'h6B2;
        end
        bit_en_i = 1'b1;
        check("R8", mism, 0, "clock pulses versus bit enables");
        decode(1'b0, "R8");
    endtask

    task automatic t_powerdown();
        do_reset(1'b0);
        pulse_strobe(12'h0F0);
        wait_start_bit();
        pulse_strobe(12'h0AA);
        pulse_strobe(12'h055);
        check("R7", ovf_o, 1, "overflow before power-down");
        @(negedge clk);
        pwrdn_i = 1'b1;
        @(negedge clk);
        check("R9", {oe_o, ser_o, fwd_clk_o, ovf_o}, 0, "outputs one cycle into power-down");
        run(3);
        pwrdn_i = 1'b0;
        exp_n = 0;
        run(70);
        decode(1'b0, "R9");
        check("R9", ovf_o, 0, "overflow cleared by power-down");
    endtask

    initial begin
        t_idle();
        t_standard();
        t_overclock();
        t_long_strobe();
        t_hold_overflow();
        t_gapped();
        t_powerdown();
        finish_run();
    end
endmodule